// File: doc/BRIEF.md
# Over-Range-Guarded Receive Attenuation Controller

This block drives a 6-bit receive-path step attenuator, in 1 dB steps from 0 to 63 dB. It takes two inputs: a coarse 4-bit level code from an averaging power meter, and an over-range flag from the converter. Normal acquisition walks the attenuation down one step at a time until the meter reports its top code. That code, all ones, stands for an input about 1 dB under full scale. A reading of zero needs care: a faint input produces it, and so does a converter driven far past full scale. The controller therefore never takes a zero at face value. It checks the zero against the previous reading and against a record of recent over-range events before it will remove attenuation.

Over-range always wins. It sets the attenuation to at least a configured safe level in the next clock and opens a holdoff window. In that window no decision is made. After every 1 dB change a dwell window of meter strobes lets the averaging settle. Steady top-code readings hold the attenuation, and after a configured run of them a lock flag rises.

The control state machine has four states:
- TRACK: strobes are judged.
- SETTLE: dwell after a step.
- GUARD: holdoff after an over-range.
- LOCK: steady at the top code.

Its transitions are:
- step: TRACK or LOCK to SETTLE, when a strobe changes the attenuation.
- settle_done: SETTLE to TRACK, when the last dwell strobe arrives.
- overload: any state to GUARD, on an over-range.
- guard_done: GUARD to TRACK, when the last holdoff strobe arrives with no new over-range.
- lock_in: TRACK to LOCK, on the LOCK_N-th consecutive top-code hold.
- unlock: LOCK to TRACK, when a strobe is judged and keeps the attenuation without a top code.

Top module: `atten_guard_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets att_word to 63 and locked to 0, enters TRACK, and clears the holdoff, dwell and lock counters. It also sets the remembered previous reading to 0 and the over-range history to clear, so a zero strobe right after reset lowers att_word by 1.
- R2: att_word changes by at most 1 per clock unless ovr is high. With meter_vld and ovr both low, att_word does not change.
- R3: A judged strobe (state TRACK or LOCK) with a code from 1 to 14 lowers att_word by 1. At 0 it holds.
- R4: A judged strobe with code 0 lowers att_word by 1 only when two things are true: the over-range history is clear, and the previous valid reading (of any state) was ZERO_TRUST_MAX or less.
- R5: A judged zero strobe that fails the R4 test raises att_word by 1, saturating at 63.
- R6: When ovr is high at a clock edge, att_word becomes max(att_word, SAFE_ATT) after that edge, whatever meter_vld and meter_code are. The state becomes GUARD, and the over-range history is set.
- R7: In GUARD no strobe is judged and att_word stays put. The HOLDOFF_N-th strobe with no further ovr returns to TRACK. Each new ovr restarts the count.
- R8: The over-range history is cleared only by a judged strobe with a nonzero code.
- R9: After any 1 dB change, the next DWELL_N strobes are not judged (SETTLE). The last of them returns to TRACK.
- R10: A judged code of 15 holds att_word. locked goes high after LOCK_N consecutive such holds. Any other judged outcome, and any ovr, drops locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| meter_vld | input | 1 | One-cycle strobe: meter_code holds a fresh averaged reading |
| meter_code | input | CODE_W | Power meter level code, 15 is near full scale, 0 is weak or overloaded |
| ovr | input | 1 | Converter over-range flag, sampled every clock |
| att_word | output | ATT_W | Attenuation in dB, one LSB per dB |
| locked | output | 1 | High while the controller sits in LOCK |

## Verification
The bench builds the controller with DWELL_N=1, HOLDOFF_N=3 and LOCK_N=3, so that every other strobe can step, a restarted holdoff shows up within a handful of strobes, and lock arrives after three top codes. SAFE_ATT is set to 61, just above the attenuation reached during the walk. An over-range jump therefore visibly raises the word, and an over-range at 63 shows that the jump never lowers it. With these values a full walk from 63 down to the floor of 0 takes 126 strobes, so the lower limit is exercised alongside the upper saturation.

// File: rtl/atg_pkg.sv
package atg_pkg;

    // Control states of the attenuation loop
    typedef enum logic [1:0] {
        ST_TRACK  = 2'd0,
        ST_SETTLE = 2'd1,
        ST_GUARD  = 2'd2,
        ST_LOCK   = 2'd3
    } atg_state_e;

    // Outcome of judging one meter strobe
    typedef enum logic [1:0] {
        DEC_KEEP  = 2'd0,
        DEC_LOWER = 2'd1,
        DEC_RAISE = 2'd2,
        DEC_FULL  = 2'd3
    } atg_dec_e;

endpackage

// File: rtl/atg_judge.sv
// Combinational judgement of one meter reading, including zero disambiguation
module atg_judge
    import atg_pkg::*;
#(
    parameter int CODE_W         = 4,
    parameter int ATT_W          = 6,
    parameter int ZERO_TRUST_MAX = 8
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] prev_code,
    input  logic              ovr_hist,
    input  logic [ATT_W-1:0]  att,
    output atg_dec_e          dec
);
    localparam logic [CODE_W-1:0] CODE_TOP   = '1;
    localparam logic [CODE_W-1:0] CODE_TRUST = CODE_W'(ZERO_TRUST_MAX);
    localparam logic [ATT_W-1:0]  ATT_TOP    = '1;

    atg_dec_e raw;

    always_comb begin
        if (code == CODE_TOP) begin
            raw = DEC_FULL;
        end else if (code == '0) begin
            // zero is trusted as weak only with clean history and a low prior reading
            if (!ovr_hist && (prev_code <= CODE_TRUST)) raw = DEC_LOWER;
            else                                         raw = DEC_RAISE;
        end else begin
            raw = DEC_LOWER;
        end
    end

    // apply the attenuator range limits
    always_comb begin
        dec = raw;
        if (raw == DEC_LOWER && att == '0)     dec = DEC_KEEP;
        if (raw == DEC_RAISE && att == ATT_TOP) dec = DEC_KEEP;
    end

endmodule

// File: rtl/atg_strobe_cnt.sv
// Loadable down counter stepped by meter strobes; flags its final strobe
module atg_strobe_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                        cnt_q <= '0;
        else if (load)                  cnt_q <= load_val;
        else if (tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == W'(1));

endmodule

// File: rtl/atg_history.sv
// Remembers the previous valid reading and whether over-range has been seen
module atg_history #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              meter_vld,
    input  logic [CODE_W-1:0] meter_code,
    input  logic              ovr,
    input  logic              judged,
    output logic [CODE_W-1:0] prev_code,
    output logic              ovr_hist
);
    always_ff @(posedge clk) begin
        if (rst)            prev_code <= '0;
        else if (meter_vld) prev_code <= meter_code;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ovr_hist <= 1'b0;
        else if (ovr)
            ovr_hist <= 1'b1;
        else if (judged && meter_code != '0)
            ovr_hist <= 1'b0;
    end

endmodule

// File: rtl/atten_guard_ctrl.sv
// Receive attenuation controller guarded by the converter over-range flag
module atten_guard_ctrl
    import atg_pkg::*;
#(
    parameter int CODE_W         = 4,
    parameter int ATT_W          = 6,
    parameter int SAFE_ATT       = 30,
    parameter int ZERO_TRUST_MAX = 8,
    parameter int DWELL_N        = 2,
    parameter int HOLDOFF_N      = 16,
    parameter int LOCK_N         = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              meter_vld,
    input  logic [CODE_W-1:0] meter_code,
    input  logic              ovr,
    output logic [ATT_W-1:0]  att_word,
    output logic              locked
);
    localparam int DWELL_W = (DWELL_N < 1)   ? 1 : $clog2(DWELL_N + 1);
    localparam int HOLD_W  = (HOLDOFF_N < 1) ? 1 : $clog2(HOLDOFF_N + 1);
    localparam int LOCK_W  = (LOCK_N < 1)    ? 1 : $clog2(LOCK_N + 1);
    localparam logic [ATT_W-1:0]   ATT_TOP   = '1;
    localparam logic [ATT_W-1:0]   ATT_SAFE  = ATT_W'(SAFE_ATT);
    localparam logic [DWELL_W-1:0] DWELL_LD  = DWELL_W'(DWELL_N);
    localparam logic [HOLD_W-1:0]  HOLD_LD   = HOLD_W'(HOLDOFF_N);
    localparam logic [LOCK_W-1:0]  LOCK_LAST = LOCK_W'(LOCK_N - 1);

    atg_state_e        state_q, state_d;
    logic [ATT_W-1:0]  att_q, att_d;
    logic [LOCK_W-1:0] lock_q, lock_d;
    logic              dwell_ld, dwell_tick, dwell_last;
    logic              hold_ld, hold_tick, hold_last;
    logic              judged;
    logic [CODE_W-1:0] prev_code;
    logic              ovr_hist;
    atg_dec_e          dec;
    logic              guard_active;
    atg_state_e        step_state;

    atg_judge #(
        .CODE_W         (CODE_W),
        .ATT_W          (ATT_W),
        .ZERO_TRUST_MAX (ZERO_TRUST_MAX)
    ) u_judge (
        .code      (meter_code),
        .prev_code (prev_code),
        .ovr_hist  (ovr_hist),
        .att       (att_q),
        .dec       (dec)
    );

    atg_history #(.CODE_W(CODE_W)) u_hist (
        .clk        (clk),
        .rst        (rst),
        .meter_vld  (meter_vld),
        .meter_code (meter_code),
        .ovr        (ovr),
        .judged     (judged),
        .prev_code  (prev_code),
        .ovr_hist   (ovr_hist)
    );

    atg_strobe_cnt #(.W(DWELL_W)) u_dwell (
        .clk      (clk),
        .rst      (rst),
        .load     (dwell_ld),
        .load_val (DWELL_LD),
        .tick     (dwell_tick),
        .last     (dwell_last)
    );

    atg_strobe_cnt #(.W(HOLD_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .load     (hold_ld),
        .load_val (HOLD_LD),
        .tick     (hold_tick),
        .last     (hold_last)
    );

    // a step with no dwell configured goes straight back to tracking
    generate
        if (DWELL_N == 0) begin : g_no_dwell
            assign step_state = ST_TRACK;
        end else begin : g_dwell
            assign step_state = ST_SETTLE;
        end
    endgenerate

    // state, attenuation and lock-run registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_TRACK;
            att_q   <= ATT_TOP;
            lock_q  <= '0;
        end else begin
            state_q <= state_d;
            att_q   <= att_d;
            lock_q  <= lock_d;
        end
    end

    // next-state and transition logic
    always_comb begin
        state_d    = state_q;
        att_d      = att_q;
        lock_d     = lock_q;
        dwell_ld   = 1'b0;
        dwell_tick = 1'b0;
        hold_ld    = 1'b0;
        hold_tick  = 1'b0;
        judged     = 1'b0;

        if (ovr) begin
            // overload: jump up to the safe level, never down
            if (att_q < ATT_SAFE) att_d = ATT_SAFE;
            hold_ld = 1'b1;
            lock_d  = '0;
            state_d = ST_GUARD;
        end else if (meter_vld) begin
            unique case (state_q)
                ST_SETTLE: begin
                    dwell_tick = 1'b1;
                    if (dwell_last) state_d = ST_TRACK;
                end
                ST_GUARD: begin
                    hold_tick = 1'b1;
                    if (hold_last) state_d = ST_TRACK;
                end
                ST_TRACK, ST_LOCK: begin
                    judged = 1'b1;
                    unique case (dec)
                        DEC_FULL: begin
                            if (state_q == ST_TRACK) begin
                                lock_d = lock_q + 1'b1;
                                if (lock_q == LOCK_LAST) state_d = ST_LOCK;
                            end
                        end
                        DEC_LOWER: begin
                            att_d    = att_q - 1'b1;
                            lock_d   = '0;
                            dwell_ld = 1'b1;
                            state_d  = step_state;
                        end
                        DEC_RAISE: begin
                            att_d    = att_q + 1'b1;
                            lock_d   = '0;
                            dwell_ld = 1'b1;
                            state_d  = step_state;
                        end
                        DEC_KEEP: begin
                            lock_d  = '0;
                            state_d = ST_TRACK;
                        end
                    endcase
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        att_word     = att_q;
        locked       = (state_q == ST_LOCK);
        guard_active = (state_q == ST_GUARD);
    end

endmodule

// File: rtl/atg_checker.sv
// Temporal checks for the attenuation controller
module atg_checker #(
    parameter int CODE_W   = 4,
    parameter int ATT_W    = 6,
    parameter int SAFE_ATT = 30
) (
    input logic              clk,
    input logic              rst,
    input logic              meter_vld,
    input logic [CODE_W-1:0] meter_code,
    input logic              ovr,
    input logic [ATT_W-1:0]  att_word,
    input logic              locked,
    input logic              guard_active
);
    localparam logic [ATT_W-1:0] ATT_TOP  = '1;
    localparam logic [ATT_W-1:0] ATT_SAFE = ATT_W'(SAFE_ATT);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (att_word == ATT_TOP) && !locked); // R1

    AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!meter_vld && !ovr) |=> $stable(att_word)); // R2

    AST_ONE_DB_STEP: assert property (@(posedge clk) disable iff (rst)
        !ovr |=> (({1'b0, att_word} == {1'b0, $past(att_word)})
               || ({1'b0, att_word} == {1'b0, $past(att_word)} + 1'b1)
               || ({1'b0, att_word} + 1'b1 == {1'b0, $past(att_word)}))); // R2

    AST_OVR_SAFE: assert property (@(posedge clk) disable iff (rst)
        ovr |=> (att_word >= ATT_SAFE) && (att_word >= $past(att_word))); // R6

    AST_GUARD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (guard_active && !ovr) |=> (att_word == $past(att_word))); // R7

    AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> ($past(meter_vld) && ($past(meter_code) == '1) && !$past(ovr))); // R10

    AST_OVR_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
        ovr |=> !locked); // R10

endmodule

bind atten_guard_ctrl atg_checker #(
    .CODE_W   (CODE_W),
    .ATT_W    (ATT_W),
    .SAFE_ATT (SAFE_ATT)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .meter_vld    (meter_vld),
    .meter_code   (meter_code),
    .ovr          (ovr),
    .att_word     (att_word),
    .locked       (locked),
    .guard_active (guard_active)
);

// File: tb/sim_atten_guard_ctrl.sv
`timescale 1ns/1ps
module sim_atten_guard_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       meter_vld = 1'b0;
    logic [3:0] meter_code = '0;
    logic       ovr = 1'b0;
    logic [5:0] att_word;
    logic       locked;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    atten_guard_ctrl #(
        .CODE_W         (4),
        .ATT_W          (6),
        .SAFE_ATT       (61),
        .ZERO_TRUST_MAX (8),
        .DWELL_N        (1),
        .HOLDOFF_N      (3),
        .LOCK_N         (3)
    ) u0 (
        .clk        (clk),
        .rst        (rst),
        .meter_vld  (meter_vld),
        .meter_code (meter_code),
        .ovr        (ovr),
        .att_word   (att_word),
        .locked     (locked)
    );

    // {vld, ovr, code[3:0], expected att[5:0], expected locked}
    localparam int NV = 37;
    localparam logic [12:0] VEC [NV] = '{
        {1'b1, 1'b0, 4'd0,  6'd62, 1'b0},  // R4 clean zero lowers
        {1'b1, 1'b0, 4'd0,  6'd62, 1'b0},  // R9 dwell strobe
        {1'b1, 1'b0, 4'd3,  6'd61, 1'b0},  // R3
        {1'b1, 1'b0, 4'd3,  6'd61, 1'b0},  // R9
        {1'b1, 1'b0, 4'd9,  6'd60, 1'b0},  // R3
        {1'b1, 1'b0, 4'd9,  6'd60, 1'b0},  // R9
        {1'b1, 1'b0, 4'd0,  6'd61, 1'b0},  // R5 zero after strong reading
        {1'b1, 1'b0, 4'd0,  6'd61, 1'b0},  // R9
        {1'b1, 1'b0, 4'd0,  6'd60, 1'b0},  // R4 zero after zero
        {1'b1, 1'b0, 4'd15, 6'd60, 1'b0},  // R9 top code during dwell
        {1'b1, 1'b0, 4'd15, 6'd60, 1'b0},  // R10 hold 1
        {1'b1, 1'b0, 4'd15, 6'd60, 1'b0},  // R10 hold 2
        {1'b1, 1'b0, 4'd15, 6'd60, 1'b1},  // R10 hold 3 locks
        {1'b1, 1'b0, 4'd15, 6'd60, 1'b1},  // R10 stays locked
        {1'b1, 1'b0, 4'd14, 6'd59, 1'b0},  // R10 unlock, R3
        {1'b1, 1'b0, 4'd14, 6'd59, 1'b0},  // R9
        {1'b1, 1'b1, 4'd5,  6'd61, 1'b0},  // R6 jump to safe
        {1'b1, 1'b0, 4'd0,  6'd61, 1'b0},  // R7 holdoff 1
        {1'b1, 1'b0, 4'd0,  6'd61, 1'b0},  // R7 holdoff 2
        {1'b1, 1'b0, 4'd0,  6'd61, 1'b0},  // R7 holdoff 3 ends
        {1'b1, 1'b0, 4'd0,  6'd62, 1'b0},  // R5 history forces raise
        {1'b1, 1'b0, 4'd0,  6'd62, 1'b0},  // R9
        {1'b1, 1'b0, 4'd0,  6'd63, 1'b0},  // R5
        {1'b1, 1'b0, 4'd0,  6'd63, 1'b0},  // R9
        {1'b1, 1'b0, 4'd0,  6'd63, 1'b0},  // R5 saturates at 63
        {1'b1, 1'b0, 4'd6,  6'd62, 1'b0},  // R8 nonzero clears history
        {1'b1, 1'b0, 4'd6,  6'd62, 1'b0},  // R9
        {1'b1, 1'b0, 4'd0,  6'd61, 1'b0},  // R8 zero trusted again
        {1'b1, 1'b1, 4'd2,  6'd61, 1'b0},  // R6 ovr during dwell
        {1'b1, 1'b0, 4'd2,  6'd61, 1'b0},  // R7
        {1'b1, 1'b1, 4'd2,  6'd61, 1'b0},  // R7 restart
        {1'b1, 1'b0, 4'd2,  6'd61, 1'b0},  // R7
        {1'b1, 1'b0, 4'd2,  6'd61, 1'b0},  // R7
        {1'b1, 1'b0, 4'd2,  6'd61, 1'b0},  // R7 holdoff ends
        {1'b1, 1'b0, 4'd2,  6'd60, 1'b0},  // R3 judged again
        {1'b0, 1'b0, 4'd0,  6'd60, 1'b0},  // R2 no strobe no change
        {1'b0, 1'b1, 4'd0,  6'd61, 1'b0}   // R6 ovr without strobe
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one cycle of inputs at a falling edge, sample at the next falling edge
    task automatic drive(input logic v, input logic o, input logic [3:0] c);
        meter_vld  = v;
        ovr        = o;
        meter_code = c;
        @(negedge clk);
        meter_vld  = 1'b0;
        ovr        = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #4000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 reset att", int'(att_word), 63);
        chk("R1 reset locked", int'(locked), 0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][12], VEC[i][11], VEC[i][10:7]);
            chk($sformatf("vector %0d att", i), int'(att_word), int'(VEC[i][6:1]));
            chk($sformatf("vector %0d locked", i), int'(locked), int'(VEC[i][0]));
        end

        // R6: over-range at 63 never lowers the word
        do_reset();
        drive(1'b0, 1'b1, 4'd0);
        chk("R6 ovr above safe keeps att", int'(att_word), 63);

        // R1: reset clears the over-range history and holdoff
        do_reset();
        drive(1'b1, 1'b0, 4'd0);
        chk("R1 history cleared by reset", int'(att_word), 62);

        // R3: walk to the floor and hold there
        do_reset();
        for (int k = 0; k < 126; k++) drive(1'b1, 1'b0, 4'd10);
        chk("R3 floor reached", int'(att_word), 0);
        drive(1'b1, 1'b0, 4'd10);
        chk("R3 floor holds", int'(att_word), 0);

        // R10: lock after three top codes at the floor
        drive(1'b1, 1'b0, 4'd15);
        drive(1'b1, 1'b0, 4'd15);
        chk("R10 not yet locked", int'(locked), 0);
        drive(1'b1, 1'b0, 4'd15);
        chk("R10 locked", int'(locked), 1);
        drive(1'b0, 1'b1, 4'd15);
        chk("R10 ovr drops lock", int'(locked), 0);
        chk("R6 jump from floor", int'(att_word), 61);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule